// File: doc/BRIEF.md
# Loss-of-Signal Alarm Interrupt Controller

This block collects one loss-of-signal alarm per line channel and turns it into a single interrupt for a host processor. Each alarm input is brought into the clock domain by a two-stage synchronizer. Any change of its level, up or down, is held in a pending-cause register until software clears it. A per-channel enable mask decides which pending causes drive the interrupt output. A cause that is masked is still recorded.

Software reaches three registers through a small synchronous port. The port has an address, a write enable, a read strobe, write data and registered read data. The service routine reads the pending-cause register to find the channels that interrupted. It then reads the live alarm register to see the present condition. That second read clears every pending cause. If a new change lands in the same cycle as the clearing read, the new change is kept.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset the enable mask and all pending causes are zero, irq_o is low and rdata_o is 0x00.
- R2: Address 0 is the enable mask, which can be read and written. Bit n enables channel n, so writing 0xFF enables all eight channels.
- R3: A rising or a falling level change on alarm_i[n] sets bit n of the pending-cause register at address 1. The bit is set, and visible on irq_o, after the third rising clock edge that follows the input change.
- R4: Address 2 returns the synchronized present alarm levels, one bit per channel. These lag alarm_i by two clock edges.
- R5: irq_o is high exactly when some channel has both its pending bit and its enable bit set. A masked channel still records its pending bit, and setting its enable later raises irq_o.
- R6: A read of address 2 clears all pending bits. A read of address 1 clears nothing.
- R7: A change that is detected in the same cycle as a clearing read of address 2 leaves its pending bit set.
- R8: Writes to addresses 1, 2 and 3 have no effect. Address 3 reads as 0x00.
- R9: rdata_o is loaded at the clock edge that samples rd_en_i high, with the register value as it stood before that edge. It holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_i | input | 8 | Loss-of-signal alarm level per channel, asynchronous |
| addr_i | input | 2 | Register address: 0 enable, 1 pending cause, 2 live alarm, 3 reserved |
| wr_en_i | input | 1 | Write strobe for addr_i |
| rd_en_i | input | 1 | Read strobe for addr_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The alarms are driven with single-channel rising and falling steps, so that the bench can confirm that both edges latch and that the latency is exact. A multi-bit pattern that sets and drops several channels at once shows that each channel is tracked on its own. Masked steps followed by a later enable separate recording from signalling. An alarm step timed to land in the same cycle as a clearing read of the live register shows that the new event wins over the clear. A behavioural model built on a history queue predicts irq_o and rdata_o on every cycle.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_EN   = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_LIVE = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int NUM_CH = 8,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] async_i,
  output logic [NUM_CH-1:0] sync_o
);
  logic [NUM_CH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/alarm_chg_latch.sv
module alarm_chg_latch #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] live_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] chg_o,
  output logic [NUM_CH-1:0] stat_o
);
  logic [NUM_CH-1:0] prev_q;
  logic [NUM_CH-1:0] stat_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign chg_o[c] = live_i[c] ^ prev_q[c];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q[c] <= 1'b0;
          stat_q[c] <= 1'b0;
        end else begin
          prev_q[c] <= live_i[c];
          // a fresh change overrides a clear in the same cycle
          stat_q[c] <= chg_o[c] | (stat_q[c] & ~clr_i);
        end
      end
    end
  endgenerate

  assign stat_o = stat_q;
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] stat_i,
  input  logic [NUM_CH-1:0] live_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] rdata_o,
  output logic              clr_o
);
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] rdata_q;
  logic [NUM_CH-1:0] rd_mux;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(addr_i);

  always_comb begin
    unique case (addr)
      ADDR_EN:   rd_mux = en_q;
      ADDR_STAT: rd_mux = stat_i;
      ADDR_LIVE: rd_mux = live_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en_i && addr == ADDR_EN) en_q <= wdata_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign clr_o   = rd_en_i && (addr == ADDR_LIVE);
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] alarm_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] live;
  logic [NUM_CH-1:0] chg;
  logic [NUM_CH-1:0] stat;
  logic [NUM_CH-1:0] en;
  logic              clr;

  alarm_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(alarm_i),
    .sync_o (live)
  );

  alarm_chg_latch #(.NUM_CH(NUM_CH)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .live_i(live),
    .clr_i (clr),
    .chg_o (chg),
    .stat_o(stat)
  );

  alarm_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .wdata_i(wdata_i),
    .stat_i (stat),
    .live_i (live),
    .en_o   (en),
    .rdata_o(rdata_o),
    .clr_o  (clr)
  );

  assign irq_o = |(stat & en);
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk
  import alarm_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [NUM_CH-1:0] wdata_i,
  input logic [NUM_CH-1:0] rdata_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] en,
  input logic [NUM_CH-1:0] stat,
  input logic [NUM_CH-1:0] chg
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!irq_o && en == '0 && stat == '0 && rdata_o == '0);
    end
  end

  p_en_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_EN) |=> (en == $past(wdata_i)));

  p_irq_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en != '0));

  p_clear_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_LIVE && chg == '0) |=> (stat == '0));

  p_change_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg != '0) |=> ((stat & $past(chg)) == $past(chg)));

  p_ro_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != ADDR_EN) |=> $stable(en));

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .en     (en),
  .stat   (stat),
  .chg    (chg)
);

// File: tb/alarm_irq_ctrl_tb.sv
module alarm_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] alarm_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  alarm_irq_ctrl u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .alarm_i(alarm_i),
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  // behavioural reference: alarm history, newest first
  logic [7:0] hist[$];
  logic [7:0] m_en, m_lat, m_rd;
  logic [7:0] m_chg, m_live_old;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist  = '{8'h00, 8'h00, 8'h00, 8'h00};
      m_en  = '0;
      m_lat = '0;
      m_rd  = '0;
    end else begin
      m_live_old = hist[1];
      m_chg      = hist[1] ^ hist[2];
      if (rd_en_i) begin
        case (addr_i)
          2'd0:    m_rd = m_en;
          2'd1:    m_rd = m_lat;
          2'd2:    m_rd = m_live_old;
          default: m_rd = 8'h00;
        endcase
      end
      if (rd_en_i && addr_i == 2'd2) m_lat = 8'h00;
      m_lat = m_lat | m_chg;
      if (wr_en_i && addr_i == 2'd0) m_en = wdata_i;
      hist.push_front(alarm_i);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (irq_o !== |(m_lat & m_en)) begin
        errors++;
        $display("FAIL R5 model irq_o act=%b exp=%b t=%0t", irq_o, |(m_lat & m_en), $time);
      end
      checks++;
      if (rdata_o !== m_rd) begin
        errors++;
        $display("FAIL R9 model rdata_o act=%02h exp=%02h t=%0t", rdata_o, m_rd, $time);
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a);
    addr_i = a; rd_en_i = 1'b1;
    step(1);
    rd_en_i = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    chk("R1 rdata after reset", rdata_o, 8'h00);
    rst_ni = 1'b1;
    step(2);
    rd(2'd0);
    chk("R1 enable after reset", rdata_o, 8'h00);

    wr(2'd0, 8'hFF);
    rd(2'd0);
    chk("R2 enable readback", rdata_o, 8'hFF);

    // R3: rising edge, exact latency
    alarm_i = 8'h01;
    step(2);
    chk("R3 irq before third edge", {7'd0, irq_o}, 8'h00);
    step(1);
    chk("R3 irq after third edge", {7'd0, irq_o}, 8'h01);
    rd(2'd1);
    chk("R3 pending rising", rdata_o, 8'h01);
    chk("R6 status read keeps irq", {7'd0, irq_o}, 8'h01);
    rd(2'd2);
    chk("R4 live level", rdata_o, 8'h01);
    chk("R6 live read clears irq", {7'd0, irq_o}, 8'h00);
    rd(2'd1);
    chk("R6 pending cleared", rdata_o, 8'h00);

    // R3: falling edge
    alarm_i = 8'h00;
    step(3);
    rd(2'd1);
    chk("R3 pending falling", rdata_o, 8'h01);
    rd(2'd2);
    chk("R4 live after fall", rdata_o, 8'h00);

    // R5: masked channel records but does not signal
    wr(2'd0, 8'hFE);
    alarm_i = 8'h01;
    step(3);
    chk("R5 masked no irq", {7'd0, irq_o}, 8'h00);
    rd(2'd1);
    chk("R5 masked still latched", rdata_o, 8'h01);
    wr(2'd0, 8'hFF);
    chk("R5 enable raises irq", {7'd0, irq_o}, 8'h01);
    rd(2'd2);
    chk("R6 clear after unmask", {7'd0, irq_o}, 8'h00);

    // R7: change coincides with clearing read
    alarm_i = 8'h09;
    step(2);
    rd(2'd2);
    chk("R7 live at collision", rdata_o, 8'h09);
    chk("R7 irq survives clear", {7'd0, irq_o}, 8'h01);
    rd(2'd1);
    chk("R7 pending survives clear", rdata_o, 8'h08);
    rd(2'd2);

    // R8: writes to read-only and reserved addresses
    wr(2'd1, 8'h55);
    wr(2'd2, 8'h55);
    wr(2'd3, 8'h55);
    rd(2'd0);
    chk("R8 enable untouched", rdata_o, 8'hFF);
    rd(2'd3);
    chk("R8 reserved reads zero", rdata_o, 8'h00);
    rd(2'd1);
    chk("R8 pending untouched", rdata_o, 8'h00);

    // multi-channel pattern, partial mask
    wr(2'd0, 8'h0F);
    alarm_i = 8'hA5;
    step(3);
    chk("R5 partial mask irq", {7'd0, irq_o}, 8'h01);
    rd(2'd1);
    chk("R3 multi-channel pending", rdata_o, 8'hAC);
    rd(2'd2);
    chk("R4 multi-channel live", rdata_o, 8'hA5);
    wr(2'd0, 8'hF0);
    alarm_i = 8'hA4;
    step(3);
    chk("R5 masked low channel", {7'd0, irq_o}, 8'h00);
    rd(2'd1);
    chk("R5 masked low latched", rdata_o, 8'h01);

    // R9: read data holds without a strobe
    rd(2'd0);
    chk("R9 read value", rdata_o, 8'hF0);
    alarm_i = 8'hFF;
    wr(2'd0, 8'h33);
    step(5);
    chk("R9 rdata held", rdata_o, 8'hF0);

    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule